// File: doc/BRIEF.md
# Record/playback control sequencer

This block is the timing and control core of a voice message recorder built around a segmented sample store. It takes three active-low push-button style inputs (record, edge-triggered play, level-held play) and two flags read back from the store (end-of-message found, store full). From these it produces the per-sample strobe, the write strobes for samples and for the end marker, the speaker enable, an active-low record lamp, a segment-advance tick for the address logic, and a standby indication. The sample strobe is made from the system clock by a divide-by-two stage followed by a further divider. Analog processing, the storage cells and address decoding sit outside the block.

Record always wins. A record request during playback cuts the playback off at once. Releasing record is filtered over a window measured in sample periods, so switch bounce does not split one recording into two. The play inputs are not filtered. The block drops to standby after every cycle. A play input that is still held low at the end does not restart playback; only a fresh falling edge does. There is no data stream at the edge of this block: every pin is a plain control or status level or a one-clock pulse, and none of them uses a handshake.

Top module: `msgseq_ctrl`

## Requirements
- R1: After reset, power_down is 1, spk_en is 0, rec_led_n is 1, and wr_en and wr_eom are 0.
- R2: sample_tick is a one-clock pulse repeating every SAMPLE_DIV clocks (a divide-by-two stage followed by a divide-by-SAMPLE_DIV/2 stage).
- R3: While recording, rec_led_n and spk_en are 0 and wr_en pulses once on each sample_tick (never when mem_full is 1).
- R4: A record cycle ends on the filtered release of rec_n or on mem_full, with exactly one one-clock wr_eom pulse followed by power_down=1. If the store filled while rec_n is still low, the block stays powered down with no wr_en until rec_n is released.
- R5: A falling edge on play_edge_n starts playback (spk_en=1, power_down=0). Returning play_edge_n high has no effect. Playback ends only on eom_in or mem_full.
- R6: A falling edge on play_level_n starts playback. Returning that input high ends it and goes straight to standby, with no record-lamp pulse.
- R7: A release of rec_n ends recording only after rec_n has stayed high for DEBOUNCE_SAMPLES consecutive sample ticks. A shorter high interval leaves recording running with no wr_eom.
- R8: When eom_in (or mem_full) is seen during playback, spk_en drops and rec_led_n is held 0 for exactly LED_PULSE sample ticks, then the block enters standby.
- R9: After any cycle ends, a play input that is still held low does not restart playback. Only a new falling edge does.
- R10: seg_tick pulses once per SEG_SAMPLES sample ticks counted during a record or play cycle, one clock after the sample tick that completes the count. The count restarts at 0 for every cycle.
- R11: A record request during playback stops playback and starts recording within 5 clocks of rec_n falling (two synchronizer flops, the request flop and the state flop).
- R12: power_down is 1 only in standby. It is never 1 while spk_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_n | input | 1 | Record request, active low |
| play_edge_n | input | 1 | Play start on falling edge, active low |
| play_level_n | input | 1 | Play while held low, active low |
| eom_in | input | 1 | End-of-message flag read back from the store |
| mem_full | input | 1 | Store-full / overflow flag |
| sample_tick | output | 1 | One-clock strobe per sample period |
| wr_en | output | 1 | Sample write strobe |
| wr_eom | output | 1 | One-clock end-marker write pulse |
| spk_en | output | 1 | Speaker driver enable (0 means high impedance) |
| rec_led_n | output | 1 | Record lamp, active low |
| seg_tick | output | 1 | Segment-advance pulse |
| power_down | output | 1 | Standby indication |

## Verification
The bench targets the edges of each timing window. A release shorter than the filter window must not end a recording; a design that filters too little writes a spurious end marker and goes to standby. A play input still held low after end-of-message must not restart playback; a level-sensitive start would loop back into playback. The record lamp pulse is counted in sample ticks, so an off-by-one counter gives a pulse one tick too long or too short. The bench also checks that segment ticks restart with each cycle, that a record press overrides playback within a few clocks, and that recording into a full store leaves the block in standby until rec_n is released.

// File: rtl/msgseq_pkg.sv
package msgseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_REC        = 3'd1,
    ST_REC_END    = 3'd2,
    ST_FULL_HOLD  = 3'd3,
    ST_PLAY_EDGE  = 3'd4,
    ST_PLAY_LEVEL = 3'd5,
    ST_EOM_FLASH  = 3'd6
  } seq_state_e;

  localparam int NUM_CTRL_IN = 3;

endpackage

// File: rtl/msgseq_tick_gen.sv
module msgseq_tick_gen #(
  parameter int SAMPLE_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int HALF = SAMPLE_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic          phase;
  logic [CW-1:0] cnt;

  // divide by two first, then count half-rate enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      cnt   <= '0;
      tick  <= 1'b0;
    end else begin
      phase <= ~phase;
      tick  <= 1'b0;
      if (phase) begin
        if (cnt == CW'(HALF - 1)) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/msgseq_input_cond.sv
module msgseq_input_cond
  import msgseq_pkg::*;
#(
  parameter int DEBOUNCE_SAMPLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_tick,
  input  logic rec_n,
  input  logic play_edge_n,
  input  logic play_level_n,
  output logic rec_req,
  output logic play_edge_start,
  output logic play_level_start,
  output logic play_level_held
);
  localparam int DW = (DEBOUNCE_SAMPLES > 1) ? $clog2(DEBOUNCE_SAMPLES) : 1;

  logic [NUM_CTRL_IN-1:0] raw;
  logic [NUM_CTRL_IN-1:0] synced;
  logic [NUM_CTRL_IN-1:0] falls;

  assign raw = {play_level_n, play_edge_n, rec_n};

  // two-flop synchronizer and falling-edge detector per control input
  for (genvar i = 0; i < NUM_CTRL_IN; i++) begin : g_sync
    logic st1, st2, last;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1  <= 1'b1;
        st2  <= 1'b1;
        last <= 1'b1;
      end else begin
        st1  <= raw[i];
        st2  <= st1;
        last <= st2;
      end
    end
    assign synced[i] = st2;
    assign falls[i]  = last & ~st2;
  end

  assign play_edge_start  = falls[1];
  assign play_level_start = falls[2];
  assign play_level_held  = ~synced[2];

  // record request: asserts at once, releases only after a steady high window
  logic [DW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_req <= 1'b0;
      hi_cnt  <= '0;
    end else if (!synced[0]) begin
      rec_req <= 1'b1;
      hi_cnt  <= '0;
    end else if (rec_req && sample_tick) begin
      if (hi_cnt == DW'(DEBOUNCE_SAMPLES - 1)) begin
        rec_req <= 1'b0;
        hi_cnt  <= '0;
      end else begin
        hi_cnt <= hi_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/msgseq_seg_counter.sv
module msgseq_seg_counter #(
  parameter int SEG_SAMPLES = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic sample_tick,
  output logic seg_tick
);
  localparam int SW = (SEG_SAMPLES > 1) ? $clog2(SEG_SAMPLES) : 1;

  logic [SW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      seg_tick <= 1'b0;
    end else if (!active) begin
      cnt      <= '0;
      seg_tick <= 1'b0;
    end else begin
      seg_tick <= 1'b0;
      if (sample_tick) begin
        if (cnt == SW'(SEG_SAMPLES - 1)) begin
          cnt      <= '0;
          seg_tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/msgseq_fsm.sv
module msgseq_fsm
  import msgseq_pkg::*;
#(
  parameter int LED_PULSE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_tick,
  input  logic rec_req,
  input  logic play_edge_start,
  input  logic play_level_start,
  input  logic play_level_held,
  input  logic eom_in,
  input  logic mem_full,
  output logic wr_en,
  output logic wr_eom,
  output logic spk_en,
  output logic rec_led_n,
  output logic power_down,
  output logic cycle_active
);
  localparam int LW = (LED_PULSE > 1) ? $clog2(LED_PULSE) : 1;

  seq_state_e    state, nxt;
  logic [LW-1:0] flash_cnt;
  logic          flash_done;

  assign flash_done = sample_tick && (flash_cnt == LW'(LED_PULSE - 1));

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (rec_req)               nxt = ST_REC;
        else if (play_edge_start)  nxt = ST_PLAY_EDGE;
        else if (play_level_start) nxt = ST_PLAY_LEVEL;
      end
      ST_REC: begin
        if (!rec_req || mem_full) nxt = ST_REC_END;
      end
      ST_REC_END: begin
        nxt = rec_req ? ST_FULL_HOLD : ST_IDLE;
      end
      ST_FULL_HOLD: begin
        if (!rec_req) nxt = ST_IDLE;
      end
      ST_PLAY_EDGE: begin
        if (rec_req)                nxt = ST_REC;
        else if (eom_in || mem_full) nxt = ST_EOM_FLASH;
      end
      ST_PLAY_LEVEL: begin
        if (rec_req)                nxt = ST_REC;
        else if (eom_in || mem_full) nxt = ST_EOM_FLASH;
        else if (!play_level_held)   nxt = ST_IDLE;
      end
      ST_EOM_FLASH: begin
        if (rec_req)         nxt = ST_REC;
        else if (flash_done) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      flash_cnt <= '0;
    end else begin
      state <= nxt;
      if (state != ST_EOM_FLASH || flash_done) flash_cnt <= '0;
      else if (sample_tick)                   flash_cnt <= flash_cnt + 1'b1;
    end
  end

  assign wr_en        = (state == ST_REC) && sample_tick && !mem_full;
  assign wr_eom       = (state == ST_REC_END);
  assign spk_en       = (state == ST_PLAY_EDGE) || (state == ST_PLAY_LEVEL);
  assign rec_led_n    = !((state == ST_REC) || (state == ST_REC_END) ||
                          (state == ST_EOM_FLASH));
  assign power_down   = (state == ST_IDLE) || (state == ST_FULL_HOLD);
  assign cycle_active = (state == ST_REC) || spk_en;

endmodule

// File: rtl/msgseq_ctrl.sv
module msgseq_ctrl #(
  parameter int SAMPLE_DIV       = 128,
  parameter int SEG_SAMPLES      = 800,
  parameter int DEBOUNCE_SAMPLES = 400,
  parameter int LED_PULSE        = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rec_n,
  input  logic play_edge_n,
  input  logic play_level_n,
  input  logic eom_in,
  input  logic mem_full,
  output logic sample_tick,
  output logic wr_en,
  output logic wr_eom,
  output logic spk_en,
  output logic rec_led_n,
  output logic seg_tick,
  output logic power_down
);
  logic rec_req, play_edge_start, play_level_start, play_level_held;
  logic cycle_active;

  msgseq_tick_gen #(.SAMPLE_DIV(SAMPLE_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (sample_tick)
  );

  msgseq_input_cond #(.DEBOUNCE_SAMPLES(DEBOUNCE_SAMPLES)) u_cond (
    .clk             (clk),
    .rst_n           (rst_n),
    .sample_tick     (sample_tick),
    .rec_n           (rec_n),
    .play_edge_n     (play_edge_n),
    .play_level_n    (play_level_n),
    .rec_req         (rec_req),
    .play_edge_start (play_edge_start),
    .play_level_start(play_level_start),
    .play_level_held (play_level_held)
  );

  msgseq_fsm #(.LED_PULSE(LED_PULSE)) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .sample_tick     (sample_tick),
    .rec_req         (rec_req),
    .play_edge_start (play_edge_start),
    .play_level_start(play_level_start),
    .play_level_held (play_level_held),
    .eom_in          (eom_in),
    .mem_full        (mem_full),
    .wr_en           (wr_en),
    .wr_eom          (wr_eom),
    .spk_en          (spk_en),
    .rec_led_n       (rec_led_n),
    .power_down      (power_down),
    .cycle_active    (cycle_active)
  );

  msgseq_seg_counter #(.SEG_SAMPLES(SEG_SAMPLES)) u_seg (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (cycle_active),
    .sample_tick(sample_tick),
    .seg_tick   (seg_tick)
  );

endmodule

// File: rtl/msgseq_ctrl_chk.sv
module msgseq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sample_tick,
  input logic wr_en,
  input logic wr_eom,
  input logic spk_en,
  input logic rec_led_n,
  input logic seg_tick,
  input logic power_down
);

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);

  // R3
  wr_quiet_spk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!rec_led_n && !spk_en));

  // R4
  eom_to_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eom |=> (power_down && !wr_eom));

  // R10
  seg_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_tick |-> $past(sample_tick));

  // R12
  spk_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spk_en |-> (!power_down && rec_led_n));

  // R12
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> (!wr_en && !wr_eom && rec_led_n));

endmodule

bind msgseq_ctrl msgseq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_tick(sample_tick),
  .wr_en      (wr_en),
  .wr_eom     (wr_eom),
  .spk_en     (spk_en),
  .rec_led_n  (rec_led_n),
  .seg_tick   (seg_tick),
  .power_down (power_down)
);

// File: tb/msgseq_ctrl_test.sv
`timescale 1ns/1ps
module msgseq_ctrl_test;
  localparam int DIV = 8, SEG = 5, DEB = 4, LEDP = 3;
  localparam logic [2:0] T_IDLE = 3'b101, T_REC = 3'b000, T_PLAY = 3'b011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rec_n = 1'b1, play_edge_n = 1'b1, play_level_n = 1'b1;
  logic eom_in = 1'b0, mem_full = 1'b0;
  logic sample_tick, wr_en, wr_eom, spk_en, rec_led_n, seg_tick, power_down;

  int n_checks = 0, n_fail = 0;
  bit mon_en = 1'b0, done = 1'b0;
  logic [2:0] last_st;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  msgseq_ctrl #(.SAMPLE_DIV(DIV), .SEG_SAMPLES(SEG), .DEBOUNCE_SAMPLES(DEB),
                .LED_PULSE(LEDP)) uut (
    .clk(clk), .rst_n(rst_n), .rec_n(rec_n), .play_edge_n(play_edge_n),
    .play_level_n(play_level_n), .eom_in(eom_in), .mem_full(mem_full),
    .sample_tick(sample_tick), .wr_en(wr_en), .wr_eom(wr_eom), .spk_en(spk_en),
    .rec_led_n(rec_led_n), .seg_tick(seg_tick), .power_down(power_down));

  function automatic logic [2:0] cur_st();
    return {power_down, spk_en, rec_led_n};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic push(input logic [2:0] s, input string req);
    exp_q.push_back(s);
    tag_q.push_back(req);
  endtask

  // monitor side: every change of {power_down, spk_en, rec_led_n} is popped
  always @(negedge clk) begin
    if (mon_en && cur_st() !== last_st) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard", "unexpected status", int'(cur_st()), int'(last_st));
      end else begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cur_st() === e, t, "status sequence", int'(cur_st()), int'(e));
      end
      last_st = cur_st();
    end
  end

  task automatic wait_st(input logic [2:0] s, input int lim, input string req);
    int n = 0;
    while (cur_st() !== s && n < lim) begin
      @(negedge clk);
      n++;
    end
    check(cur_st() === s, req, "reach status", int'(cur_st()), int'(s));
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", "run timed out", 0, 1);
    report();
  end

  initial begin
    int cnt, cnt2, n;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(power_down == 1'b1 && spk_en == 1'b0 && rec_led_n == 1'b1,
          "R1", "reset status", int'(cur_st()), int'(T_IDLE));
    check(wr_en == 1'b0 && wr_eom == 1'b0, "R1", "reset strobes",
          int'({wr_en, wr_eom}), 0);
    rst_n = 1'b1;
    last_st = cur_st();
    mon_en = 1'b1;

    // R2 sample tick spacing and width
    n = 0;
    while (!sample_tick && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    check(!sample_tick, "R2", "tick width", int'(sample_tick), 0);
    cnt = 1;
    while (!sample_tick && cnt < 100) begin @(negedge clk); cnt++; end
    check(cnt == DIV, "R2", "tick period", cnt, DIV);

    // R5 edge play ignores rising input, R8 lamp pulse on eom
    push(T_PLAY, "R5"); push(T_REC, "R8"); push(T_IDLE, "R8");
    play_edge_n = 1'b0;
    wait_st(T_PLAY, 20, "R5");
    play_edge_n = 1'b1;
    repeat (4 * DIV) @(negedge clk);
    check(spk_en == 1'b1, "R5", "still playing after release", int'(spk_en), 1);
    eom_in = 1'b1;
    cnt = 0; n = 0;
    while (!power_down && n < 200) begin
      @(negedge clk); n++;
      if (!rec_led_n && sample_tick) cnt++;
    end
    check(cnt == LEDP, "R8", "lamp pulse ticks", cnt, LEDP);
    eom_in = 1'b0;
    repeat (20) @(negedge clk);
    check(power_down == 1'b1, "R9", "edge play stays down", int'(power_down), 1);

    // R6 level play stops on release, no lamp pulse
    push(T_PLAY, "R6"); push(T_IDLE, "R6");
    play_level_n = 1'b0;
    wait_st(T_PLAY, 20, "R6");
    repeat (2 * DIV) @(negedge clk);
    play_level_n = 1'b1;
    wait_st(T_IDLE, 20, "R6");

    // R9 level still held at eom does not restart
    push(T_PLAY, "R9"); push(T_REC, "R8"); push(T_IDLE, "R9");
    play_level_n = 1'b0;
    wait_st(T_PLAY, 20, "R9");
    eom_in = 1'b1;
    wait_st(T_IDLE, 20 * DIV, "R9");
    eom_in = 1'b0;
    repeat (10 * DIV) @(negedge clk);
    check(power_down == 1'b1 && spk_en == 1'b0, "R9", "held play no restart",
          int'(cur_st()), int'(T_IDLE));
    play_level_n = 1'b1;
    repeat (4) @(negedge clk);
    push(T_PLAY, "R9");
    play_level_n = 1'b0;
    wait_st(T_PLAY, 20, "R9");
    push(T_IDLE, "R6");
    play_level_n = 1'b1;
    wait_st(T_IDLE, 20, "R6");

    // R10 segment ticks restart per cycle
    push(T_PLAY, "R10"); push(T_IDLE, "R10");
    play_level_n = 1'b0;
    cnt = 0; cnt2 = 0;
    while (cnt < 23) begin
      @(negedge clk);
      if (spk_en && sample_tick) cnt++;
      if (seg_tick) cnt2++;
    end
    play_level_n = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (spk_en && sample_tick) cnt++;
      if (seg_tick) cnt2++;
    end
    check(cnt2 == cnt / SEG, "R10", "segment ticks", cnt2, cnt / SEG);

    // R3 recording writes per sample; R7/R4 filtered release and end marker
    push(T_REC, "R3"); push(T_IDLE, "R4");
    rec_n = 1'b0;
    wait_st(T_REC, 20, "R3");
    cnt = 0; n = 0;
    repeat (6 * DIV) begin
      @(negedge clk);
      if (wr_en) cnt++;
      if (spk_en) n++;
    end
    check(cnt == 6, "R3", "writes per sample", cnt, 6);
    check(n == 0, "R3", "speaker off while recording", n, 0);
    rec_n = 1'b1;
    cnt = 0; cnt2 = 0; n = 0;
    while (!power_down && n < 200) begin
      @(negedge clk); n++;
      if (sample_tick) cnt++;
      if (wr_eom) cnt2++;
    end
    check(cnt >= DEB && cnt <= DEB + 1, "R7", "release filter ticks", cnt, DEB);
    check(cnt2 == 1, "R4", "end marker pulses", cnt2, 1);

    // R7 short release does not end the recording
    push(T_REC, "R7");
    rec_n = 1'b0;
    wait_st(T_REC, 20, "R7");
    rec_n = 1'b1;
    cnt2 = 0;
    repeat ((DEB - 2) * DIV) begin @(negedge clk); if (wr_eom) cnt2++; end
    rec_n = 1'b0;
    repeat (4 * DIV) begin @(negedge clk); if (wr_eom) cnt2++; end
    check(cnt2 == 0, "R7", "no marker on glitch", cnt2, 0);
    check(rec_led_n == 1'b0 && power_down == 1'b0, "R7", "still recording",
          int'(cur_st()), int'(T_REC));
    push(T_IDLE, "R4");
    rec_n = 1'b1;
    wait_st(T_IDLE, 20 * DIV, "R4");

    // R11 record overrides playback
    push(T_PLAY, "R11");
    play_edge_n = 1'b0;
    wait_st(T_PLAY, 20, "R11");
    play_edge_n = 1'b1;
    repeat (DIV) @(negedge clk);
    push(T_REC, "R11");
    rec_n = 1'b0;
    n = 0;
    while (rec_led_n && n < 50) begin @(negedge clk); n++; end
    check(n <= 5, "R11", "clocks to preempt", n, 5);
    check(spk_en == 1'b0, "R11", "speaker off", int'(spk_en), 0);
    push(T_IDLE, "R4");
    rec_n = 1'b1;
    wait_st(T_IDLE, 20 * DIV, "R4");

    // R4 store full while record held
    push(T_REC, "R4"); push(T_IDLE, "R4");
    rec_n = 1'b0;
    wait_st(T_REC, 20, "R4");
    mem_full = 1'b1;
    cnt2 = 0; n = 0;
    while (!power_down && n < 20) begin
      @(negedge clk); n++;
      if (wr_eom) cnt2++;
    end
    check(cnt2 == 1, "R4", "marker on full", cnt2, 1);
    cnt = 0;
    repeat (3 * DIV) begin @(negedge clk); if (wr_en || !power_down) cnt++; end
    check(cnt == 0, "R4", "held while full", cnt, 0);
    rec_n = 1'b1;
    repeat ((DEB + 2) * DIV) @(negedge clk);
    mem_full = 1'b0;
    repeat (4) @(negedge clk);
    check(power_down == 1'b1 && rec_led_n == 1'b1, "R12", "standby after full",
          int'(cur_st()), int'(T_IDLE));
    push(T_REC, "R3"); push(T_IDLE, "R4");
    rec_n = 1'b0;
    wait_st(T_REC, 20, "R3");
    rec_n = 1'b1;
    wait_st(T_IDLE, 20 * DIV, "R4");

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard", "items left", exp_q.size(), 0);
    report();
  end
endmodule